// File: doc/BRIEF.md
# Integer Execution Unit: Adder, Logic, Shifter and Compare

This block is the combinational integer datapath of a small in-order RISC core. The pipeline hands it two register operands, a 16-bit immediate, a constant shift count and a 4-bit operation code. It returns one result word in the same evaluation, together with an overflow flag that the pipeline may use to raise a trap. The block does no operand forwarding and handles no exceptions; those stay in the surrounding pipeline.

The second operand can come from the register input or from the immediate. A separate flag selects whether the immediate is sign-extended, as arithmetic and compare forms need, or zero-extended, as the bitwise forms need. Shifts always shift the first operand. The shift count comes either from the constant field or from the low bits of the second operand.

Top module: `int_exec_unit`

## Requirements
- R1: Op code 0 (trapping add) and code 1 (non-trapping add) both return (A + B') modulo 2^32, where B' is the selected second operand.
- R2: Op code 2 (trapping subtract) and code 3 (non-trapping subtract) both return (A - B') modulo 2^32.
- R3: The overflow flag is 1 only for codes 0 and 2, and only when the signed two's-complement result does not fit in 32 bits. For every other code it is 0.
- R4: Codes 4, 5, 6 and 7 return the bitwise AND, OR, XOR and NOR of A and B'. NOR is the inverse of OR.
- R5: When the use-immediate input is 0, B' equals the B input. When it is 1 and the sign-extend input is 1, B' is the immediate sign-extended to 32 bits. When it is 1 and the sign-extend input is 0, B' is the immediate zero-extended to 32 bits.
- R6: With the variable-shift input at 0, codes 10, 11 and 12 shift A by the 5-bit constant count. Code 10 is a logical left shift, code 11 a logical right shift, and code 12 an arithmetic right shift that fills with the sign bit.
- R7: With the variable-shift input at 1, the shift count is bits 4:0 of B'. All higher bits of B' have no effect on the result.
- R8: Code 8 returns 1 when A is less than B' as signed numbers, and 0 otherwise.
- R9: Code 9 returns 1 when A is less than B' as unsigned numbers, and 0 otherwise.
- R10: Code 13 returns the immediate in bits 31:16 and zero in bits 15:0.
- R11: Codes 14 and 15 return zero with the overflow flag at 0.
- R12: Result and overflow are purely combinational: they follow the inputs with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand; the value that gets shifted |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | 1 selects the extended immediate as second operand |
| imm_sext_i | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| shamt_i | input | 5 | Constant shift count |
| shift_var_i | input | 1 | 1 takes the shift count from bits 4:0 of the second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| ovf_o | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 16-bit immediate and a 5-bit shift count. At that width the bench's reference model can compute exact signed sums in 64-bit integers, so overflow is judged against true arithmetic and not against a carry rule. Operands are drawn from a pool weighted toward 0, 1, the largest positive value, the most negative value and all-ones. This reaches sign-boundary overflows, signed and unsigned compare disagreements, and sign-filling shifts by 31 far more often than uniform values would. Directed vectors add variable shifts whose second operand has high bits set, and an immediate with its top bit set under both extension modes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12,
        OP_LUI  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_kind_e;

    function automatic logic needs_subtract(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
    endfunction

    function automatic logic is_trapping(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_operand.sv
module alu_operand #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [WIDTH-1:0] reg_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             sext,
    output logic [WIDTH-1:0] b_eff
);
    localparam int EXT_W = WIDTH - IMM_W;

    logic [EXT_W-1:0] ext_bits;

    always_comb begin
        ext_bits = (sext && imm[IMM_W-1]) ? {EXT_W{1'b1}} : {EXT_W{1'b0}};
        b_eff    = use_imm ? {ext_bits, imm} : reg_b;
    end

    always_comb begin
        if (!$isunknown({use_imm, sext, imm})) begin
            AST_ZERO_EXTEND: assert (!(use_imm && !sext) || (b_eff[WIDTH-1:IMM_W] == '0)); // R5
            AST_IMM_LOW_BITS: assert (!use_imm || (b_eff[IMM_W-1:0] == imm)); // R5
        end
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf_raw,
    output logic             lt_signed,
    output logic             lt_unsigned
);
    logic [WIDTH-1:0] b_inv;
    logic [WIDTH:0]   full;

    always_comb begin
        b_inv       = sub ? ~b : b;
        full        = {1'b0, a} + {1'b0, b_inv} + {{WIDTH{1'b0}}, sub};
        sum         = full[WIDTH-1:0];
        ovf_raw     = (a[WIDTH-1] == b_inv[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
        lt_signed   = sum[WIDTH-1] ^ ovf_raw;
        lt_unsigned = ~full[WIDTH];
    end

    always_comb begin
        if (!$isunknown({a, b, sub})) begin
            AST_EQUAL_NOT_LESS: assert (!(sub && (a == b)) || (!lt_signed && !lt_unsigned)); // R8
            AST_ADD_NO_OVF_MIXED: assert (!(!sub && (a[WIDTH-1] != b[WIDTH-1])) || !ovf_raw); // R3
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]  din,
    input  logic [AMT_W-1:0]  amt,
    input  alu_pkg::shift_kind_e kind,
    output logic [WIDTH-1:0]  dout
);
    import alu_pkg::*;

    logic [WIDTH-1:0] din_rev;
    logic [WIDTH-1:0] stage_q [AMT_W+1];
    logic [WIDTH-1:0] right_out;
    logic [WIDTH-1:0] right_rev;
    logic             fill;
    logic             go_left;

    assign go_left = (kind == SH_LEFT);
    assign fill    = (kind == SH_RARI) && din[WIDTH-1];

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign din_rev[i]   = din[WIDTH-1-i];
        assign right_rev[i] = right_out[WIDTH-1-i];
    end

    assign stage_q[0] = go_left ? din_rev : din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage_q[k+1] = amt[k] ? {{STEP{fill}}, stage_q[k][WIDTH-1:STEP]} : stage_q[k];
    end

    assign right_out = stage_q[AMT_W];
    assign dout      = go_left ? right_rev : right_out;

    always_comb begin
        if (!$isunknown({din, amt, kind})) begin
            AST_ZERO_SHIFT_IDENTITY: assert ((amt != '0) || (dout == din)); // R6
            AST_LOGICAL_RIGHT_TOP_CLEAR: assert (!((kind == SH_RLOG) && (amt != '0)) || !dout[WIDTH-1]); // R6
            AST_LEFT_LOW_CLEAR: assert (!((kind == SH_LEFT) && (amt != '0)) || !dout[0]); // R6
        end
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             imm_sext_i,
    input  logic [AMT_W-1:0] shamt_i,
    input  logic             shift_var_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             ovf_o
);
    import alu_pkg::*;

    localparam int LOW_W = WIDTH - IMM_W;

    alu_op_e          op;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             ovf_raw;
    logic             lt_s;
    logic             lt_u;
    logic [WIDTH-1:0] sh_out;
    logic [AMT_W-1:0] sh_amt;
    shift_kind_e      sh_kind;
    logic_kind_e      lg_kind;
    logic [WIDTH-1:0] lg_out;

    assign op = alu_op_e'(op_i);

    alu_operand #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_operand (
        .reg_b   (b_i),
        .imm     (imm_i),
        .use_imm (use_imm_i),
        .sext    (imm_sext_i),
        .b_eff   (b_eff)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a           (a_i),
        .b           (b_eff),
        .sub         (needs_subtract(op)),
        .sum         (sum),
        .ovf_raw     (ovf_raw),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    always_comb begin
        sh_amt = shift_var_i ? b_eff[AMT_W-1:0] : shamt_i;
        unique case (op)
            OP_SRL:  sh_kind = SH_RLOG;
            OP_SRA:  sh_kind = SH_RARI;
            default: sh_kind = SH_LEFT;
        endcase
        lg_kind = logic_kind_e'(op_i[1:0]);
    end

    alu_shifter #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_shifter (
        .din  (a_i),
        .amt  (sh_amt),
        .kind (sh_kind),
        .dout (sh_out)
    );

    always_comb begin
        unique case (lg_kind)
            LG_AND:  lg_out = a_i & b_eff;
            LG_OR:   lg_out = a_i | b_eff;
            LG_XOR:  lg_out = a_i ^ b_eff;
            default: lg_out = ~(a_i | b_eff);
        endcase
    end

    always_comb begin
        result_o = '0;
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:    result_o = lg_out;
            OP_SLT:                           result_o = {{(WIDTH-1){1'b0}}, lt_s};
            OP_SLTU:                          result_o = {{(WIDTH-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA:           result_o = sh_out;
            OP_LUI:                           result_o = {imm_i, {LOW_W{1'b0}}};
            default:                          result_o = '0;
        endcase
        ovf_o = is_trapping(op) && ovf_raw;
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, imm_i, use_imm_i, imm_sext_i, shamt_i, shift_var_i, op_i})) begin
            AST_OVF_TRAP_ONLY: assert (!ovf_o || (op == OP_ADD) || (op == OP_SUB)); // R3
            AST_ADD_SIGN_OVF: assert (!((op == OP_ADD) && (a_i[WIDTH-1] == b_eff[WIDTH-1])
                                        && (result_o[WIDTH-1] != a_i[WIDTH-1])) || ovf_o); // R3
            AST_SET_IS_BIT: assert (!((op == OP_SLT) || (op == OP_SLTU)) || (result_o[WIDTH-1:1] == '0)); // R8
            AST_NOR_DISJOINT: assert ((op != OP_NOR) || ((result_o & a_i) == '0)); // R4
            AST_UPPER_IMM_LOW_ZERO: assert ((op != OP_LUI) || (result_o[LOW_W-1:0] == '0)); // R10
            AST_RESERVED_ZERO: assert (!((op == OP_RSV0) || (op == OP_RSV1)) || (result_o == '0 && !ovf_o)); // R11
        end
    end
endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_i, b_i;
    logic [15:0] imm_i;
    logic        use_imm_i, imm_sext_i, shift_var_i;
    logic [4:0]  shamt_i;
    logic [3:0]  op_i;
    logic [31:0] result_o;
    logic        ovf_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    int_exec_unit u_int_exec_unit (
        .a_i         (a_i),
        .b_i         (b_i),
        .imm_i       (imm_i),
        .use_imm_i   (use_imm_i),
        .imm_sext_i  (imm_sext_i),
        .shamt_i     (shamt_i),
        .shift_var_i (shift_var_i),
        .op_i        (op_i),
        .result_o    (result_o),
        .ovf_o       (ovf_o)
    );

    function automatic logic [31:0] pick_b(logic [31:0] b, logic [15:0] imm, logic ui, logic se);
        if (!ui) return b;
        if (se) return {{16{imm[15]}}, imm};
        return {16'h0000, imm};
    endfunction

    function automatic logic [32:0] model(logic [31:0] a, logic [31:0] b, logic [15:0] imm,
                                          logic ui, logic se, logic [4:0] sa, logic sv, logic [3:0] op);
        logic [31:0] bv;
        logic [4:0]  n;
        longint      sa64, sb64, s64;
        logic        v;
        logic [31:0] r;
        bv   = pick_b(b, imm, ui, se);
        n    = sv ? bv[4:0] : sa;
        sa64 = longint'($signed(a));
        sb64 = longint'($signed(bv));
        v    = 1'b0;
        r    = 32'h0;
        case (op)
            4'd0, 4'd1: begin
                r = a + bv;
                s64 = sa64 + sb64;
                v = (op == 4'd0) && (s64 > 64'sd2147483647 || s64 < -64'sd2147483648);
            end
            4'd2, 4'd3: begin
                r = a - bv;
                s64 = sa64 - sb64;
                v = (op == 4'd2) && (s64 > 64'sd2147483647 || s64 < -64'sd2147483648);
            end
            4'd4:  r = a & bv;
            4'd5:  r = a | bv;
            4'd6:  r = a ^ bv;
            4'd7:  r = ~(a | bv);
            4'd8:  r = (sa64 < sb64) ? 32'd1 : 32'd0;
            4'd9:  r = (a < bv) ? 32'd1 : 32'd0;
            4'd10: r = a << n;
            4'd11: r = a >> n;
            4'd12: r = 32'($signed(a) >>> n);
            4'd13: r = {imm, 16'h0000};
            default: r = 32'h0;
        endcase
        return {v, r};
    endfunction

    function automatic string req_of(logic [3:0] op, logic sv, logic ui);
        case (op)
            4'd0, 4'd1: return ui ? "R1/R5" : "R1";
            4'd2, 4'd3: return "R2";
            4'd4, 4'd5, 4'd6, 4'd7: return ui ? "R4/R5" : "R4";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10, 4'd11, 4'd12: return sv ? "R7" : "R6";
            4'd13: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic apply_check(logic [31:0] a, logic [31:0] b, logic [15:0] imm, logic ui, logic se,
                               logic [4:0] sa, logic sv, logic [3:0] op, string tag);
        logic [32:0] exp;
        @(negedge clk);
        a_i = a; b_i = b; imm_i = imm; use_imm_i = ui; imm_sext_i = se;
        shamt_i = sa; shift_var_i = sv; op_i = op;
        #2;
        exp = model(a, b, imm, ui, se, sa, sv, op);
        n_checks++;
        if (result_o !== exp[31:0] || ovf_o !== exp[32]) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h: got res=%h ovf=%b, expected res=%h ovf=%b",
                     tag, op, a, b, imm, result_o, ovf_o, exp[31:0], exp[32]);
        end
    endtask

    function automatic logic [31:0] rnd_word();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL R12 watchdog expired: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        a_i = '0; b_i = '0; imm_i = '0; use_imm_i = 0; imm_sext_i = 0;
        shamt_i = '0; shift_var_i = 0; op_i = 4'd0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R12: quiet inputs give zero result immediately
        apply_check(32'h0, 32'h0, 16'h0, 0, 0, 5'd0, 0, 4'd0, "R12 idle");

        // R1 / R3: add overflow at the sign boundary, non-trapping form stays quiet
        apply_check(32'h7FFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, 4'd0, "R3 add ovf");
        apply_check(32'h7FFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, 4'd1, "R3 addu no ovf");
        apply_check(32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 0, 0, 5'd0, 0, 4'd0, "R3 neg add ovf");
        // R2 / R3: subtract overflow
        apply_check(32'h8000_0000, 32'h1, 16'h0, 0, 0, 5'd0, 0, 4'd2, "R3 sub ovf");
        apply_check(32'h8000_0000, 32'h1, 16'h0, 0, 0, 5'd0, 0, 4'd3, "R2 subu wrap");
        // R5: immediate 0x8000 under both extension modes
        apply_check(32'h0000_0000, 32'h0, 16'h8000, 1, 1, 5'd0, 0, 4'd0, "R5 sext add");
        apply_check(32'hFFFF_FFFF, 32'h0, 16'h8000, 1, 0, 5'd0, 0, 4'd4, "R5 zext and");
        // R8 / R9: signed vs unsigned disagreement
        apply_check(32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, 4'd8, "R8 -1<1");
        apply_check(32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, 4'd9, "R9 max<1");
        apply_check(32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 0, 5'd0, 0, 4'd8, "R8 min<max");
        // R6: arithmetic fill at maximum count
        apply_check(32'h8000_0000, 32'h0, 16'h0, 0, 0, 5'd31, 0, 4'd12, "R6 sra 31");
        apply_check(32'h8000_0000, 32'h0, 16'h0, 0, 0, 5'd31, 0, 4'd11, "R6 srl 31");
        // R7: high bits of the count operand ignored (0xFFFFFFE5 -> count 5)
        apply_check(32'h0000_00F1, 32'hFFFF_FFE5, 16'h0, 0, 0, 5'd1, 1, 4'd10, "R7 sllv high bits");
        apply_check(32'hF000_0000, 32'h0000_0120, 16'h0, 0, 0, 5'd7, 1, 4'd12, "R7 srav count 0");
        // R10, R11
        apply_check(32'h1234_5678, 32'h0, 16'hBEEF, 1, 1, 5'd0, 0, 4'd13, "R10 upper imm");
        apply_check(32'h7FFF_FFFF, 32'h1, 16'h0, 0, 0, 5'd0, 0, 4'd14, "R11 code 14");
        apply_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 0, 5'd3, 0, 4'd15, "R11 code 15");
        // R4: NOR
        apply_check(32'h0F0F_0000, 32'h00FF_00F0, 16'h0, 0, 0, 5'd0, 0, 4'd7, "R4 nor");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            logic [3:0]  rop;
            logic        rui, rsv;
            ra  = rnd_word();
            rb  = rnd_word();
            rop = 4'($urandom % 16);
            rui = ($urandom % 3) == 0;
            rsv = $urandom % 2;
            apply_check(ra, rb, 16'($urandom), rui, 1'($urandom), 5'($urandom), rsv, rop,
                        req_of(rop, rsv, rui));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule